// File: doc/BRIEF.md
# I2C Bit-Rate Prescaler

This block derives the bus timing strobes for an I2C master from a fast core clock. A single 8-bit configuration word holds two divider fields. One is a linear factor M, which divides by M+1. The other is an exponent N, which divides by 2^(N+1). Chained, the two stages give one sample tick every (M+1)·2^(N+1) core cycles. A modulo-10 phase counter turns ten ticks into one SCL bit period, with SCL low for the first five ticks and high for the last five. The resulting bus rate is core_clk / (10·(M+1)·2^(N+1)).

The byte engine of the master has two uses for the block. It consumes the one-cycle `tick` to sample and drive SDA, and it follows `scl_hi` as the SCL level it should put on the bus. The engine gates the whole generator with `run_en`. Software picks M and N for its target rate and writes them through `cfg_we`/`cfg_wdata`. A write restarts every counter, so the first period after a change is a whole one. The reset value (M=9, N=1) gives 100 kHz from a 40 MHz core clock, so the block runs at a usable rate before it is configured.

Top module: `i2c_rate_gen`

## Requirements
- R1: With N = cfg_wdata[2:0] and M = cfg_wdata[6:3], consecutive `tick` pulses are exactly (M+1)·2^(N+1) core cycles apart while `run_en` is high.
- R2: One SCL period spans 10 tick periods. `scl_hi` is low for 5 tick periods and then high for 5, and it changes only in the cycle after a tick.
- R3: After reset M=9 and N=1, which gives a 40-cycle tick period. While `rst_n` is low, `tick` and `scl_hi` are 0. Reset release is synchronised over two cycles, so with `run_en` high the first tick comes 41 cycles after the cycle in which `rst_n` rises.
- R4: `tick` is high for exactly one core cycle at a time.
- R5: While `run_en` is low, `tick` is 0 and `scl_hi` is 0 from the next cycle on. If `run_en` is raised in cycle e, the first tick falls in cycle e+P−1, where P is the tick period.
- R6: A configuration write in cycle w restarts all counters. No tick occurs in cycle w, the first tick falls in cycle w+P_new, and `scl_hi` is low from w+1 until it rises in cycle w+5·P_new+1.
- R7: cfg_wdata[7] has no effect on the rates.
- R8: A configuration written while `run_en` is low is kept and sets the rate once `run_en` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Generator enable from the byte engine |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration data: N in [2:0], M in [6:3] |
| tick | output | 1 | One-cycle sample strobe |
| scl_hi | output | 1 | SCL phase: 1 in the high half of the bit period |

## Verification
The divider pairs are chosen so that each stage is tested apart from the other. M=0,N=0 gives the shortest period of two cycles. M=15,N=0 exercises the linear stage alone, and M=1,N=4 is mostly the power-of-two stage. M=3,N=2 mixes both stages, and M=15,N=7 is the largest period. An error in the M+1 or the 2^(N+1) term therefore shows up as a different tick gap for a known pair. The SCL rise and fall times measured after a write separate a wrong phase split or a missed restart from a wrong divider. The enable, bit-7 and write-while-disabled cases each check a latency that only correct clearing and field decoding can produce.

// File: rtl/i2c_rate_pkg.sv
`timescale 1ns/1ps
package i2c_rate_pkg;
  localparam int M_W   = 4;          // linear factor field width
  localparam int N_W   = 3;          // exponent field width
  localparam int CFG_W = M_W + N_W;
  localparam int POW_W = 1 << N_W;   // widest power-of-two counter

  typedef struct packed {
    logic [M_W-1:0] m;   // bits [6:3]
    logic [N_W-1:0] n;   // bits [2:0]
  } rate_cfg_t;
endpackage

// File: rtl/i2c_rate_lin_div.sv
`timescale 1ns/1ps
module i2c_rate_lin_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic         stb
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en, at_end;

  always_comb begin
    at_end = (cnt_q == lim);
    cnt_en = clr | run | (|cnt_q);
    if (clr || !run)  cnt_d = '0;
    else if (at_end)  cnt_d = '0;
    else              cnt_d = cnt_q + W'(1);
    stb = run & ~clr & at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R1: count never passes the programmed limit
  p_lin_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);
  // R6: a restart clears the linear stage
  p_lin_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_rate_pow_div.sv
`timescale 1ns/1ps
module i2c_rate_pow_div #(
  parameter int NW = 3,
  localparam int CW = 1 << NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic          adv,
  input  logic [NW-1:0] exp_n,
  output logic          stb
);
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          cnt_en, at_end;

  // terminal count 2^(N+1)-1: bits 0..N set
  for (genvar i = 0; i < CW; i++) begin : g_lim
    assign lim[i] = (exp_n >= NW'(i));
  end

  always_comb begin
    at_end = (cnt_q == lim);
    cnt_en = clr | ~run | adv;
    if (clr || !run)  cnt_d = '0;
    else if (at_end)  cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
    stb = adv & at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R1: power-of-two stage stays within 2^(N+1)-1
  p_pow_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);
  // R6: a restart clears the power-of-two stage
  p_pow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_rate_phase.sv
`timescale 1ns/1ps
module i2c_rate_phase #(
  parameter int PHASES = 10,
  localparam int HALF = PHASES / 2,
  localparam int PW   = $clog2(PHASES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic hi
);
  logic [PW-1:0] ph_q, ph_d;
  logic          ph_en;

  always_comb begin
    ph_en = clr | adv;
    if (clr)                             ph_d = '0;
    else if (ph_q == PW'(PHASES - 1))    ph_d = '0;
    else                                 ph_d = ph_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  assign hi = (ph_q >= PW'(HALF));

  // R2: phase index stays inside one bit period
  p_ph_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < PW'(PHASES));
  // R2: the SCL phase moves only on a tick or a restart
  p_ph_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(ph_q));
endmodule

// File: rtl/i2c_rate_gen.sv
`timescale 1ns/1ps
module i2c_rate_gen
  import i2c_rate_pkg::*;
#(
  parameter int WDATA_W = 8,
  parameter int PHASES  = 10,
  parameter int RST_M   = 9,
  parameter int RST_N   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               cfg_we,
  input  logic [WDATA_W-1:0] cfg_wdata,
  output logic               tick,
  output logic               scl_hi
);
  localparam rate_cfg_t RST_CFG = '{m: M_W'(RST_M), n: N_W'(RST_N)};

  // reset: asynchronous assertion, two-flop synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // configuration register
  rate_cfg_t cfg_q, cfg_d;
  logic      cfg_unused_bits;
  assign cfg_d           = rate_cfg_t'(cfg_wdata[CFG_W-1:0]);
  assign cfg_unused_bits = ^cfg_wdata[WDATA_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  cfg_q <= RST_CFG;
    else if (cfg_we)  cfg_q <= cfg_d;
  end

  logic lin_stb, pow_stb, ph_clr;

  i2c_rate_lin_div #(.W(M_W)) u_lin (
    .clk  (clk),
    .rst_n(rst_core_n),
    .run  (run_en),
    .clr  (cfg_we),
    .lim  (cfg_q.m),
    .stb  (lin_stb)
  );

  i2c_rate_pow_div #(.NW(N_W)) u_pow (
    .clk  (clk),
    .rst_n(rst_core_n),
    .run  (run_en),
    .clr  (cfg_we),
    .adv  (lin_stb),
    .exp_n(cfg_q.n),
    .stb  (pow_stb)
  );

  assign ph_clr = cfg_we | ~run_en;

  i2c_rate_phase #(.PHASES(PHASES)) u_phase (
    .clk  (clk),
    .rst_n(rst_core_n),
    .clr  (ph_clr),
    .adv  (pow_stb),
    .hi   (scl_hi)
  );

  assign tick = pow_stb;

  // R4: tick is a single-cycle pulse
  p_single_tick_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    tick |=> !tick);
  // R5: nothing is produced while disabled
  p_idle_tick_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run_en |-> !tick);
  p_idle_scl_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run_en |=> !scl_hi);
  // R6: a write restarts the bit period in its low half
  p_restart_low_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_we |=> !scl_hi);
endmodule

// File: tb/i2c_rate_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_en;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       tick;
  logic       scl_hi;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_rate_gen dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .tick     (tick),
    .scl_hi   (scl_hi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_tick(output int c);
    do @(negedge clk); while (!tick);
    c = cyc;
  endtask

  task automatic wait_scl(input bit lvl, output int c);
    do @(negedge clk); while (scl_hi !== lvl);
    c = cyc;
  endtask

  task automatic write_cfg(input logic [7:0] d, output int w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d; w = cyc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R3: reset values and release timing
  task automatic t_reset();
    int k0, t1, t2;
    rst_n = 1'b0; run_en = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    chk(tick == 1'b0 && scl_hi == 1'b0, "R3", "outputs in reset",
        {tick, scl_hi}, 0);
    rst_n = 1'b1; k0 = cyc;
    wait_tick(t1);
    chk(t1 - k0 == 41, "R3", "first tick after release", t1 - k0, 41);
    wait_tick(t2);
    chk(t2 - t1 == 40, "R3", "default tick period", t2 - t1, 40);
  endtask

  // R1 R2 R4 R6: one divider pair
  task automatic t_pair(input int m, input int n, input bit do_scl);
    int p, w, t1, t2, r, f, r2;
    p = (m + 1) * (1 << (n + 1));
    write_cfg(8'((m << 3) | n), w);
    wait_tick(t1);
    chk(t1 - w == p, "R6", $sformatf("first tick after write m=%0d n=%0d", m, n),
        t1 - w, p);
    @(negedge clk);
    chk(tick == 1'b0, "R4", "tick width", tick, 0);
    wait_tick(t2);
    chk(t2 - t1 == p, "R1", $sformatf("tick period m=%0d n=%0d", m, n),
        t2 - t1, p);
    if (do_scl) begin
      wait_scl(1'b1, r);
      chk(r - w == 5 * p + 1, "R6", "SCL rise after write", r - w, 5 * p + 1);
      wait_scl(1'b0, f);
      chk(f - r == 5 * p, "R2", "SCL high time", f - r, 5 * p);
      wait_scl(1'b1, r2);
      chk(r2 - r == 10 * p, "R2", "SCL period", r2 - r, 10 * p);
    end
  endtask

  // R7: top data bit ignored
  task automatic t_bit7();
    int w, t1, t2;
    write_cfg(8'h80 | 8'((2 << 3) | 0), w);
    wait_tick(t1);
    chk(t1 - w == 6, "R7", "latency with bit7 set", t1 - w, 6);
    wait_tick(t2);
    chk(t2 - t1 == 6, "R7", "period with bit7 set", t2 - t1, 6);
  endtask

  // R5 R8: disable, reprogram while idle, re-enable
  task automatic t_disable();
    int bad, w, e, t1, t2;
    bad = 0;
    @(negedge clk);
    run_en = 1'b0;
    if (tick !== 1'b0) bad++;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tick !== 1'b0 || scl_hi !== 1'b0) bad++;
    end
    chk(bad == 0, "R5", "idle outputs quiet", bad, 0);
    write_cfg(8'((4 << 3) | 0), w);
    repeat (20) @(negedge clk);
    chk(tick == 1'b0, "R5", "no tick after idle write", tick, 0);
    run_en = 1'b1; e = cyc;
    wait_tick(t1);
    chk(t1 - e == 9, "R5", "first tick after enable", t1 - e, 9);
    wait_tick(t2);
    chk(t2 - t1 == 10, "R8", "rate written while idle", t2 - t1, 10);
  endtask

  initial begin
    t_reset();
    t_pair(0, 0, 1'b1);
    t_pair(3, 2, 1'b1);
    t_pair(15, 0, 1'b1);
    t_pair(1, 4, 1'b1);
    t_pair(15, 7, 1'b0);
    t_bit7();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule